// File: doc/BRIEF.md
# Two-Master Cascaded Interrupt Aggregator

This block gathers 112 interrupt sources into one host interrupt line. The sources form fourteen groups of eight. Seven groups belong to a primary master and seven to a secondary master. Each group has its own directly addressed registers:

- a latched pending byte,
- a write-one-to-clear byte,
- a mask byte,
- a live-level byte.

Software never has to select a group through a shared window first. Each master exposes a summary byte. Bits 7:1 of that byte flag which groups hold unmasked pending sources. Bit 0 of the primary summary reports that the secondary master has something pending, which chains the two masters into one tree. The host line follows the primary summary.

Source inputs may be asynchronous. They are synchronized, and a pending bit latches on a rising edge of the synchronized level while the source is unmasked. Software services a source in three steps:

1. Read the primary summary, then the secondary summary if bit 0 is set.
2. Read the flagged group's pending byte.
3. Acknowledge the source by masking it and then writing a one to its clear bit.

Top module: `irq_cascade_agg`

## Requirements
- R1: After a synchronous reset, all pending bits are 0, all mask bits are 1 (every source masked), `irq` is 0 and `rdata` is 0.
- R2: The register windows start at 0x130 (master 0) and 0x1B0 (master 1). The window offsets are:
  - 0: summary byte.
  - 1..7: pending byte of group n at offset n.
  - 9..15: mask byte of group n at offset n+8.
  - 16..22: live level of group n at offset n+15.

  A read with `rd_en` updates `rdata` at the next clock edge. `rdata` holds between reads. Any address outside these read locations, including offset 8, returns 0.
- R3: A rising edge of a synchronized source while its mask bit is 0 sets its pending bit. Source index = ((master*7 + n − 1)*8 + bit). The edge becomes visible three clock edges after the input changes.
- R4: A source that is masked when its edge is detected does not latch. A level held high latches only once.
- R5: Writing the clear register of group n at offset n+1 clears exactly the pending bits written as 1. If a new edge on a bit arrives in the same cycle as its clear, the bit stays set.
- R6: Writing a mask byte sets each mask bit to the written value: 1 masks, 0 unmasks. The mask byte reads back as written.
- R7: Summary bit n (1..7) is the OR of (pending AND NOT mask) for group n. Masking a pending bit hides it from the summary without clearing it.
- R8: Bit 0 of the master 0 summary is set when any of bits 7:1 of the master 1 summary is set. Bit 0 of the master 1 summary always reads 0.
- R9: `irq` is registered. It is high one cycle after the master 0 summary is non-zero, and low one cycle after it becomes zero.
- R10: The live-level byte shows the synchronized source levels whatever the mask state.
- R11: After the acknowledge sequence (mask, then clear), the source stays idle: `irq` drops, and no new pending bit appears until the source is unmasked and a fresh rising edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 112 | Interrupt source levels, may be asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Host interrupt line |

## Verification
The embedded properties assume that the strobes, address and write data are well defined from the first cycle after reset and are steady across each sampling edge. They also assume that reset is held through at least one clock edge at start-up. Sources are not assumed synchronous: the properties look only at the pending and mask state behind the synchronizer, so any source waveform is allowed. The stimulus changes every input only at the falling clock edge and holds reset for several cycles. Its random phase draws addresses mostly from inside the two windows, so that the clear/edge collision, mask changes and chained summary all occur.

// File: rtl/ica_pkg.sv
package ica_pkg;
  localparam int N_MASTERS   = 2;
  localparam int BLK_PER_M   = 7;
  localparam int SRC_PER_BLK = 8;
  localparam int N_BLK       = N_MASTERS * BLK_PER_M;
  localparam int N_SRC       = N_BLK * SRC_PER_BLK;
  localparam int ADDR_W      = 10;
  localparam int DATA_W      = SRC_PER_BLK;

  localparam logic [ADDR_W-1:0] M0_BASE = 10'h130;
  localparam logic [ADDR_W-1:0] M1_BASE = 10'h1B0;

  // offsets of group n registers relative to n within a master window
  localparam int OFF_CLR  = 1;
  localparam int OFF_MASK = 8;
  localparam int OFF_RT   = 15;
  localparam int WIN_SPAN = OFF_RT + BLK_PER_M + 1;

  typedef logic [DATA_W-1:0] byte_t;

  function automatic logic [ADDR_W-1:0] master_base(int m);
    return (m == 0) ? M0_BASE : M1_BASE;
  endfunction
endpackage

// File: rtl/ica_sync.sv
module ica_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ica_block.sv
module ica_block #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] mask_q,
  output logic         any
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] arm;
  logic [W-1:0] clr_bits;

  assign rise     = lvl & ~prev_q;
  assign arm      = rise & ~mask_q;
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      prev_q <= lvl;
      // a fresh edge wins over a simultaneous clear
      stat_q <= (stat_q & ~clr_bits) | arm;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign any = |(stat_q & ~mask_q);

  // R4
  masked_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~$past(stat_q) & $past(mask_q)) == '0));

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr_we) |-> ((stat_q & $past(wdata) & ~$past(arm)) == '0));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mask_we) |-> (mask_q == $past(wdata)));
endmodule

// File: rtl/ica_regif.sv
module ica_regif
  import ica_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  byte_t                          wdata,
  input  logic [N_BLK-1:0][DATA_W-1:0]   stat_v,
  input  logic [N_BLK-1:0][DATA_W-1:0]   mask_v,
  input  logic [N_BLK-1:0][DATA_W-1:0]   rt_v,
  input  logic [N_MASTERS-1:0][DATA_W-1:0] sum_v,
  output logic [N_BLK-1:0]               clr_we,
  output logic [N_BLK-1:0]               mask_we,
  output byte_t                          rdata
);
  logic [N_MASTERS-1:0]             hit;
  logic [N_MASTERS-1:0][ADDR_W-1:0] off;
  byte_t                            rd_val;
  logic                             rd_hit;

  generate
    for (genvar m = 0; m < N_MASTERS; m++) begin : g_win
      localparam logic [ADDR_W-1:0] BASE = master_base(m);
      assign hit[m] = (addr >= BASE) && (addr < BASE + ADDR_W'(WIN_SPAN));
      assign off[m] = addr - BASE;
    end
  endgenerate

  always_comb begin
    clr_we  = '0;
    mask_we = '0;
    rd_val  = '0;
    rd_hit  = 1'b0;
    for (int m = 0; m < N_MASTERS; m++) begin
      if (hit[m]) begin
        if (off[m] == '0) begin
          rd_val = sum_v[m];
          rd_hit = 1'b1;
        end
        for (int n = 1; n <= BLK_PER_M; n++) begin
          if (off[m] == ADDR_W'(n)) begin
            rd_val = stat_v[m*BLK_PER_M + n - 1];
            rd_hit = 1'b1;
          end
          if (off[m] == ADDR_W'(n + OFF_CLR))
            clr_we[m*BLK_PER_M + n - 1] = wr_en;
          if (off[m] == ADDR_W'(n + OFF_MASK)) begin
            mask_we[m*BLK_PER_M + n - 1] = wr_en;
            rd_val = mask_v[m*BLK_PER_M + n - 1];
            rd_hit = 1'b1;
          end
          if (off[m] == ADDR_W'(n + OFF_RT)) begin
            rd_val = rt_v[m*BLK_PER_M + n - 1];
            rd_hit = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_hit) |=> (rdata == '0));
endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
  import ica_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [N_SRC-1:0]                 lvl;
  logic [N_BLK-1:0][DATA_W-1:0]     stat_v;
  logic [N_BLK-1:0][DATA_W-1:0]     mask_v;
  logic [N_BLK-1:0][DATA_W-1:0]     rt_v;
  logic [N_MASTERS-1:0][DATA_W-1:0] sum_v;
  logic [N_BLK-1:0]                 any;
  logic [N_BLK-1:0]                 clr_we;
  logic [N_BLK-1:0]                 mask_we;
  logic                             m1_pend;

  ica_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(src_in), .q(lvl)
  );

  generate
    for (genvar g = 0; g < N_BLK; g++) begin : g_blk
      assign rt_v[g] = lvl[g*SRC_PER_BLK +: SRC_PER_BLK];
      ica_block #(.W(SRC_PER_BLK)) u_blk (
        .clk    (clk),
        .rst    (rst),
        .lvl    (lvl[g*SRC_PER_BLK +: SRC_PER_BLK]),
        .clr_we (clr_we[g]),
        .mask_we(mask_we[g]),
        .wdata  (wdata),
        .stat_q (stat_v[g]),
        .mask_q (mask_v[g]),
        .any    (any[g])
      );
    end
  endgenerate

  // master 1 feeds the chain bit of master 0
  assign m1_pend  = |any[N_BLK-1:BLK_PER_M];
  assign sum_v[1] = {any[N_BLK-1:BLK_PER_M], 1'b0};
  assign sum_v[0] = {any[BLK_PER_M-1:0], m1_pend};

  ica_regif u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .stat_v(stat_v), .mask_v(mask_v), .rt_v(rt_v),
    .sum_v(sum_v), .clr_we(clr_we), .mask_we(mask_we), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |sum_v[0];
  end

  // R8
  chain_irq_chk: assert property (@(posedge clk) disable iff (rst)
    m1_pend |=> irq);

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|any));
endmodule

// File: tb/tb_irq_cascade_agg.sv
`timescale 1ns/1ps
module tb_irq_cascade_agg;
  import ica_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N_SRC-1:0]  src = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  irq_cascade_agg dut (
    .clk(clk), .rst(rst), .src_in(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0]       m_stat [14];
  logic [7:0]       m_mask [14];
  logic [N_SRC-1:0] m_s1, m_s2, m_prev, m_edge;
  logic             m_irq;
  logic [7:0]       m_rdata;
  int               wm, woff;

  function automatic int win_of(logic [9:0] a);
    if (a >= 10'h130 && a <= 10'h146) return 0;
    if (a >= 10'h1B0 && a <= 10'h1C6) return 1;
    return -1;
  endfunction

  function automatic int off_of(logic [9:0] a, int m);
    return int'(a) - ((m == 1) ? 'h1B0 : 'h130);
  endfunction

  function automatic logic [7:0] summary(int m);
    logic [7:0] r;
    r = 8'h00;
    for (int n = 1; n <= 7; n++)
      if ((m_stat[m*7+n-1] & ~m_mask[m*7+n-1]) != 0) r[n] = 1'b1;
    if (m == 0) begin
      for (int n = 1; n <= 7; n++)
        if ((m_stat[7+n-1] & ~m_mask[7+n-1]) != 0) r[0] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [7:0] model_read(logic [9:0] a);
    int m, o;
    m = win_of(a);
    if (m < 0) return 8'h00;
    o = off_of(a, m);
    if (o == 0) return summary(m);
    if (o >= 1 && o <= 7) return m_stat[m*7+o-1];
    if (o >= 9 && o <= 15) return m_mask[m*7+o-9];
    if (o >= 16 && o <= 22) return m_s2[(m*7+o-16)*8 +: 8];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < 14; g++) begin
        m_stat[g] = 8'h00;
        m_mask[g] = 8'hFF;
      end
      m_s1 = '0; m_s2 = '0; m_prev = '0;
      m_irq = 1'b0; m_rdata = 8'h00;
    end else begin
      m_edge = m_s2 & ~m_prev;
      if (rd_en) m_rdata = model_read(addr);
      m_irq = (summary(0) != 8'h00);
      wm = win_of(addr);
      woff = (wm >= 0) ? off_of(addr, wm) : -1;
      if (wr_en && woff >= 2 && woff <= 8)
        m_stat[wm*7+woff-2] = m_stat[wm*7+woff-2] & ~wdata;
      for (int g = 0; g < 14; g++)
        m_stat[g] = m_stat[g] | (m_edge[g*8 +: 8] & ~m_mask[g]);
      if (wr_en && woff >= 9 && woff <= 15)
        m_mask[wm*7+woff-9] = wdata;
      m_prev = m_s2;
      m_s2 = m_s1;
      m_s1 = src;
    end
    started = 1;
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (started) begin
      checks += 2;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R9 irq got %0b exp %0b at %0t", irq, m_irq, $time);
      end
      if (rdata !== m_rdata) begin
        errors++;
        $display("FAIL R2 rdata got %02h exp %02h at %0t", rdata, m_rdata, $time);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [9:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog expired got hang exp completion");
    finish_run();
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    rd(10'h130, 8'h00, "R1 summary after reset");
    rd(10'h139, 8'hFF, "R1 mask after reset");

    // R10 live level while masked, R4 no latch when masked
    src[0] = 1'b1;
    idle(5);
    rd(10'h140, 8'h01, "R10 live level masked");
    rd(10'h131, 8'h00, "R4 masked edge not latched");
    src[0] = 1'b0;
    idle(4);

    // R6 unmask and read back
    wr(10'h139, 8'h00);
    rd(10'h139, 8'h00, "R6 mask readback");

    // R3 latch, R7 summary, R9 irq
    src[3] = 1'b1;
    idle(6);
    rd(10'h131, 8'h08, "R3 pending bit latched");
    rd(10'h130, 8'h02, "R7 summary bit of group 1");
    chk("R9 irq high", {7'b0, irq}, 8'h01);

    // R5 clear with zero, then with one
    wr(10'h132, 8'h00);
    rd(10'h131, 8'h08, "R5 zero write keeps bit");
    wr(10'h132, 8'h08);
    idle(3);
    rd(10'h131, 8'h00, "R5 clear bit");
    chk("R9 irq low", {7'b0, irq}, 8'h00);
    idle(4);
    rd(10'h131, 8'h00, "R4 held level latches once");

    // R3/R8 master 1 group 3 bit 5 = source 77
    wr(10'h1BB, 8'hDF);
    src[77] = 1'b1;
    idle(6);
    rd(10'h1B3, 8'h20, "R3 master1 source 77");
    rd(10'h1B0, 8'h08, "R8 master1 summary bit0 zero");
    rd(10'h130, 8'h01, "R8 chain bit");
    chk("R9 irq from chain", {7'b0, irq}, 8'h01);

    // R7 masking hides without clearing, R11 acknowledge
    wr(10'h1BB, 8'hFF);
    idle(3);
    rd(10'h1B3, 8'h20, "R7 masked bit kept");
    rd(10'h1B0, 8'h00, "R7 masked hidden from summary");
    rd(10'h130, 8'h00, "R7 chain hidden");
    chk("R11 irq low after mask", {7'b0, irq}, 8'h00);
    wr(10'h1B4, 8'h20);
    rd(10'h1B3, 8'h00, "R11 clear after mask");
    src[77] = 1'b0;
    idle(4);
    src[77] = 1'b1;
    idle(6);
    rd(10'h1B3, 8'h00, "R11 edge while masked ignored");
    wr(10'h1BB, 8'hDF);
    idle(4);
    rd(10'h1B3, 8'h00, "R11 no latch after unmask");
    chk("R11 irq stays low", {7'b0, irq}, 8'h00);

    // R2 unmapped and write-only locations, live level in master 1
    rd(10'h138, 8'h00, "R2 clear location reads 0");
    rd(10'h12F, 8'h00, "R2 below window");
    rd(10'h147, 8'h00, "R2 above window");
    rd(10'h200, 8'h00, "R2 far address");
    src[111] = 1'b1;
    idle(4);
    rd(10'h1C6, 8'h80, "R10 master1 group7 live level");

    // R5 edge arriving with the clear wins
    wr(10'h13A, 8'h00);
    src[8] = 1'b1;
    idle(6);
    rd(10'h132, 8'h01, "R3 group2 bit0");
    @(negedge clk);
    src[9] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 10'h133; wdata = 8'h03;
    @(negedge clk);
    wr_en = 1'b0;
    rd(10'h132, 8'h02, "R5 edge wins over clear");

    // random phase compared every clock against the reference (R3 R5 R6 R7 R8)
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) src[$urandom_range(N_SRC-1)] ^= 1'b1;
      wr_en = ($urandom_range(4) == 0);
      rd_en = ($urandom_range(1) == 0);
      addr  = ($urandom_range(1) == 0 ? 10'h130 : 10'h1B0) + 10'($urandom_range(24));
      wdata = 8'($urandom);
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    idle(5);
    finish_run();
  end
endmodule